// File: doc/BRIEF.md
# FIFO Occupancy Flag Controller with Rewind

This block keeps the write and read addresses of a single-clock circular buffer and derives its occupancy flags. A producer asserts a write request and a consumer asserts a read request; each request is honoured only when the buffer can take it. The block hands the current write and read locations to an external storage array, which is outside this block. Four active-low flags report the fill level: empty, full, more-than-half, and a shared edge-band flag that goes low when the buffer is nearly empty or nearly full.

A rewind command moves the read location back to zero and leaves the write location where it is. This lets a consumer replay everything written since the last reset. The occupancy count is one bit wider than an address. Because of that, a buffer that was filled exactly once to capacity rewinds to a full count and not to zero. The depth is a power of two, set by the address width parameter (default 11, i.e. 2048 locations).

Top module: `fifo_occ_flags`

## Requirements
- R1: `empty_n` is 0 when the occupancy is 0 and 1 at every other occupancy.
- R2: `full_n` is 0 when the occupancy equals DEPTH and 1 at every lower occupancy.
- R3: `half_n` is 0 when the occupancy is greater than DEPTH/2 and 1 at DEPTH/2 or below.
- R4: `edge_n` is 0 when the occupancy is below DEPTH/8 or above DEPTH-DEPTH/8, and 1 in the band from DEPTH/8 to DEPTH-DEPTH/8 inclusive.
- R5: While `rst_n` is low, both addresses are 0, `empty_n` and `edge_n` are 0, and `full_n` and `half_n` are 1.
- R6: A write request while `full_n` is 0 leaves `wr_addr` and the occupancy unchanged.
- R7: A read request while `empty_n` is 0 leaves `rd_addr` and the occupancy unchanged.
- R8: An accepted write and an accepted read in the same cycle each advance their own address by one, and all four flags keep their values.
- R9: When `rewind` is high at a clock edge, `rd_addr` becomes 0 and `wr_addr` is unchanged. Write and read requests in that cycle are ignored. The occupancy becomes the value of `wr_addr`, or DEPTH when `wr_addr` is 0 and the occupancy was nonzero.
- R10: Each accepted write or read advances its address by one, and an address wraps from DEPTH-1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request |
| rd_en | input | 1 | Read request for one word |
| rewind | input | 1 | Return the read location to zero |
| wr_addr | output | ADDR_W | Location for the next write |
| rd_addr | output | ADDR_W | Location for the next read |
| full_n | output | 1 | Low when the buffer holds DEPTH words |
| empty_n | output | 1 | Low when the buffer holds no words |
| half_n | output | 1 | Low when more than half of the buffer is in use |
| edge_n | output | 1 | Low in the bottom and top eighth bands of occupancy |

## Verification
The bench builds the block with ADDR_W set to 5, a depth of 32. Every flag threshold then lies within a few dozen cycles: the edge band ends at 4 and resumes above 28, and the half mark is 16. At that size, a full fill and a full drain both wrap the two addresses past 31. The bench also covers a rewind from an exactly full buffer, where the write address has wrapped to zero, and a rewind from a partially used buffer, in both cases with requests held high during the rewind cycle.

// File: rtl/fifo_occ_pkg.sv
package fifo_occ_pkg;

   // Active-low status flags, as the decoder produces them
   typedef struct packed {
      logic full_n;
      logic empty_n;
      logic half_n;
      logic edge_n;
   } occ_flags_t;

   localparam int MIN_ADDR_W = 3;
   localparam int MAX_ADDR_W = 24;

endpackage

// File: rtl/fifo_ring_ptr.sv
module fifo_ring_ptr #(
   parameter int AW = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step,
   input  logic          home,
   output logic [AW-1:0] ptr
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ptr <= '0;
      else if (home)
         ptr <= '0;
      else if (step)
         ptr <= ptr + 1'b1;
   end

endmodule

// File: rtl/fifo_occ_cnt.sv
module fifo_occ_cnt #(
   parameter int AW = 11
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        inc,
   input  logic        dec,
   input  logic        load,
   input  logic [AW:0] load_val,
   output logic [AW:0] cnt
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= load_val;
      else if (inc && !dec)
         cnt <= cnt + 1'b1;
      else if (dec && !inc)
         cnt <= cnt - 1'b1;
   end

endmodule

// File: rtl/fifo_flag_dec.sv
module fifo_flag_dec
   import fifo_occ_pkg::*;
#(
   parameter int AW = 11
) (
   input  logic [AW:0] cnt,
   output occ_flags_t  flags
);

   localparam int DEPTH = 1 << AW;
   localparam logic [AW:0] FULL_V = (AW+1)'(DEPTH);
   localparam logic [AW:0] HALF_V = (AW+1)'(DEPTH / 2);
   localparam logic [AW:0] LOW_V  = (AW+1)'(DEPTH / 8);
   localparam logic [AW:0] HIGH_V = (AW+1)'(DEPTH - DEPTH / 8);

   always_comb begin
      flags.empty_n = (cnt != '0);
      flags.full_n  = (cnt != FULL_V);
      flags.half_n  = !(cnt > HALF_V);
      flags.edge_n  = !((cnt < LOW_V) || (cnt > HIGH_V));
   end

endmodule

// File: rtl/fifo_occ_flags.sv
module fifo_occ_flags
   import fifo_occ_pkg::*;
#(
   parameter int ADDR_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic              rewind,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              full_n,
   output logic              empty_n,
   output logic              half_n,
   output logic              edge_n
);

   localparam int DEPTH = 1 << ADDR_W;
   localparam logic [ADDR_W:0] FULL_V = (ADDR_W+1)'(DEPTH);
   localparam int N_PTR = 2;

   if (ADDR_W < MIN_ADDR_W || ADDR_W > MAX_ADDR_W) begin : g_bad_width
      $error("fifo_occ_flags: ADDR_W out of supported range");
   end

   occ_flags_t        flags;
   logic [ADDR_W:0]   occ;
   logic [ADDR_W:0]   rew_occ;
   logic              wr_ok;
   logic              rd_ok;
   logic [N_PTR-1:0]  step_v;
   logic [N_PTR-1:0]  home_v;
   logic [ADDR_W-1:0] ptr_v [N_PTR];

   assign wr_ok = wr_en && flags.full_n  && !rewind;
   assign rd_ok = rd_en && flags.empty_n && !rewind;

   // index 0 = write side, index 1 = read side
   assign step_v = {rd_ok, wr_ok};
   assign home_v = {rewind, 1'b0};

   for (genvar i = 0; i < N_PTR; i++) begin : g_ptr
      fifo_ring_ptr #(.AW(ADDR_W)) u_ptr (
         .clk   (clk),
         .rst_n (rst_n),
         .step  (step_v[i]),
         .home  (home_v[i]),
         .ptr   (ptr_v[i])
      );
   end

   assign wr_addr = ptr_v[0];
   assign rd_addr = ptr_v[1];

   // a wrapped write address with stored data means one full lap was written
   assign rew_occ = ((ptr_v[0] == '0) && (occ != '0)) ? FULL_V : {1'b0, ptr_v[0]};

   fifo_occ_cnt #(.AW(ADDR_W)) u_occ (
      .clk      (clk),
      .rst_n    (rst_n),
      .inc      (wr_ok),
      .dec      (rd_ok),
      .load     (rewind),
      .load_val (rew_occ),
      .cnt      (occ)
   );

   fifo_flag_dec #(.AW(ADDR_W)) u_dec (
      .cnt   (occ),
      .flags (flags)
   );

   assign full_n  = flags.full_n;
   assign empty_n = flags.empty_n;
   assign half_n  = flags.half_n;
   assign edge_n  = flags.edge_n;

endmodule

// File: rtl/fifo_occ_flags_chk.sv
module fifo_occ_flags_chk #(
   parameter int ADDR_W = 11
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              rd_en,
   input logic              rewind,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [ADDR_W-1:0] rd_addr,
   input logic              full_n,
   input logic              empty_n,
   input logic              half_n,
   input logic              edge_n
);

   // R5
   reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (wr_addr == '0 && rd_addr == '0 && !empty_n && !edge_n && full_n && half_n));

   // R6
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!full_n || rewind || !wr_en) |=> (wr_addr == $past(wr_addr)));

   // R7
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!empty_n && !rewind) |=> (rd_addr == $past(rd_addr)));

   // R8
   both_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && rd_en && full_n && empty_n && !rewind) |=>
      (wr_addr == ADDR_W'($past(wr_addr) + 1'b1) && rd_addr == ADDR_W'($past(rd_addr) + 1'b1) &&
       $stable(full_n) && $stable(empty_n) && $stable(half_n) && $stable(edge_n)));

   // R9
   rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rewind |=> (rd_addr == '0 && $stable(wr_addr)));

   // R2
   full_bands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !full_n |-> (empty_n && !half_n && !edge_n));

   // R1
   empty_bands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !empty_n |-> (full_n && half_n && !edge_n));

endmodule

bind fifo_occ_flags fifo_occ_flags_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .rd_en   (rd_en),
   .rewind  (rewind),
   .wr_addr (wr_addr),
   .rd_addr (rd_addr),
   .full_n  (full_n),
   .empty_n (empty_n),
   .half_n  (half_n),
   .edge_n  (edge_n)
);

// File: tb/fifo_occ_flags_bench.sv
module fifo_occ_flags_bench;

   localparam int AW = 5;
   localparam int D  = 1 << AW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic rd_en = 1'b0;
   logic rewind = 1'b0;
   logic [AW-1:0] wr_addr;
   logic [AW-1:0] rd_addr;
   logic full_n, empty_n, half_n, edge_n;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   int m_cnt = 0;
   int m_wp  = 0;
   int m_rp  = 0;

   always #4 clk = ~clk;

   fifo_occ_flags #(.ADDR_W(AW)) u_fifo_occ_flags (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .rewind(rewind),
      .wr_addr(wr_addr), .rd_addr(rd_addr),
      .full_n(full_n), .empty_n(empty_n), .half_n(half_n), .edge_n(edge_n)
   );

   task automatic chk(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic check_all(string tag);
      chk({tag, " wr_addr"}, int'(wr_addr), m_wp);
      chk({tag, " rd_addr"}, int'(rd_addr), m_rp);
      chk("R1 empty_n", int'(empty_n), (m_cnt != 0) ? 1 : 0);
      chk("R2 full_n",  int'(full_n),  (m_cnt != D) ? 1 : 0);
      chk("R3 half_n",  int'(half_n),  (m_cnt > D/2) ? 0 : 1);
      chk("R4 edge_n",  int'(edge_n),  (m_cnt < D/8 || m_cnt > D - D/8) ? 0 : 1);
   endtask

   task automatic do_cyc(bit w, bit r, bit t, string tag);
      wr_en = w; rd_en = r; rewind = t;
      if (t) begin
         m_rp  = 0;
         m_cnt = (m_wp == 0 && m_cnt != 0) ? D : m_wp;
      end else begin
         bit wok, rok;
         wok = w && (m_cnt != D);
         rok = r && (m_cnt != 0);
         if (wok) m_wp = (m_wp + 1) % D;
         if (rok) m_rp = (m_rp + 1) % D;
         m_cnt = m_cnt + (wok ? 1 : 0) - (rok ? 1 : 0);
      end
      @(posedge clk);
      #2;
      wr_en = 1'b0; rd_en = 1'b0; rewind = 1'b0;
      check_all(tag);
   endtask

   // R5: reset clears addresses and flags
   task automatic t_reset();
      #1;
      rst_n = 1'b0;
      m_cnt = 0; m_wp = 0; m_rp = 0;
      repeat (2) @(posedge clk);
      #1;
      check_all("R5");
      #2;
      rst_n = 1'b1;
   endtask

   // R1-R4, R10: fill to capacity, wrapping the write address
   task automatic t_fill();
      for (int i = 0; i < D; i++) do_cyc(1'b1, 1'b0, 1'b0, "R10 fill");
   endtask

   // R6: writes while full are dropped
   task automatic t_write_full();
      do_cyc(1'b1, 1'b0, 1'b0, "R6");
      do_cyc(1'b1, 1'b0, 1'b0, "R6");
   endtask

   // R9: rewind from exactly full, requests held high
   task automatic t_rewind(string tag);
      do_cyc(1'b1, 1'b1, 1'b1, tag);
   endtask

   // R10, R1: drain everything, wrapping the read address
   task automatic t_drain(int n);
      for (int i = 0; i < n; i++) do_cyc(1'b0, 1'b1, 1'b0, "R10 drain");
   endtask

   // R7: reads while empty are dropped
   task automatic t_read_empty();
      do_cyc(1'b0, 1'b1, 1'b0, "R7");
      do_cyc(1'b0, 1'b1, 1'b0, "R7");
   endtask

   // R8: concurrent write and read
   task automatic t_both();
      for (int i = 0; i < 10; i++) do_cyc(1'b1, 1'b0, 1'b0, "R8 prefill");
      for (int i = 0; i < 3; i++)  do_cyc(1'b0, 1'b1, 1'b0, "R8 preread");
      for (int i = 0; i < 6; i++)  do_cyc(1'b1, 1'b1, 1'b0, "R8");
   endtask

   // R8 near the edge band: both at occupancy 1 keeps empty high
   task automatic t_both_low();
      t_drain(m_cnt - 1);
      do_cyc(1'b1, 1'b1, 1'b0, "R8 low");
      do_cyc(1'b0, 1'b0, 1'b0, "R8 idle");
   endtask

   initial begin
      t_reset();
      t_fill();
      t_write_full();
      t_rewind("R9 full");
      t_drain(D);
      t_read_empty();
      t_reset();
      t_both();
      t_rewind("R9 partial");
      t_both_low();
      t_drain(m_cnt);
      t_read_empty();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog R1 actual=timeout expected=completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule